// File: doc/BRIEF.md
# SMBus Transaction Sequencer for Output-Select Registers and Seed Storage

This block is the transaction layer that sits above a serial-bus bit engine. The engine reports bus events to it as one-cycle pulses: start, stop, timeout, an address match with its read/write bit, each received byte, and each request for the next byte to transmit. The sequencer decodes the first byte after a write address as a register or command byte. It then runs the byte sequence that belongs to that command and keeps every change staged until the closing STOP.

The block holds two 8-bit output registers whose top two bits are a single shared pair of select bits. It also holds a read-only snapshot of a 5-bit input port and a 64-bit seed. A code word supplied by an external generator is read back through the block. Writes commit only at STOP and only while write protect is low. A committed register write raises a one-cycle mux update pulse, and any committed write starts a busy counter that requests clock stretching.

Top module: `smbus_seq_top`

## Requirements
- R1: A write transaction of address(W), byte 0x00 or 0x01, then one data byte, then STOP, writes data bits 5:0 into register A (0x00) or register B (0x01) and data bits 7:6 into the shared select pair. The regA/regB ports keep their old value until the cycle after STOP.
- R2: regA and regB always present the same shared select pair in bits 7:6. After reset the select pair is 10 and both low fields are 0, so both ports read 0x80.
- R3: After address(R) with no pending read command, the transmitted bytes are 0x03, regA, regB and the snapshot, in that order. Every further byte is 0xFF.
- R4: The snapshot reads {000, portIn}, with portIn sampled at the clock edge where startSeen is high. Later changes of portIn do not affect it.
- R5: Command 0xC0, then count byte 0x08, then 8 seed bytes (first byte is bits 63:56), then STOP, replaces the seed. If the count byte is not 0x08, the seed is left unchanged.
- R6: Command 0xC1, a repeated START and address(R) transmit 0x08 and then the 8 seed bytes, most significant byte first.
- R7: Command 0xC3, a repeated START and address(R) transmit 0x08 and then the 8 code bytes, most significant byte first, with bit 63 forced to 1.
- R8: If wpIn is high at STOP, nothing is committed: registers and seed keep their values, and neither muxUpdate nor stretchReq is raised.
- R9: muxUpdate is high for exactly the one cycle after a STOP that commits a register write. A write that is cut off by a repeated START or by a timeout before STOP is discarded, with no pulse.
- R10: stretchReq is high for exactly BUSY_CYCLES cycles, starting the cycle after a committing STOP.
- R11: If stopSeen and startSeen are high in the same cycle, the pending write still commits and the snapshot is still taken for the new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| startSeen | input | 1 | START or repeated START pulse |
| stopSeen | input | 1 | STOP pulse |
| timeoutSeen | input | 1 | Bus timeout pulse, aborts the transaction |
| addrHit | input | 1 | Own address received |
| addrRead | input | 1 | Read/write bit of the matched address (1 = read) |
| rxValid | input | 1 | Received byte strobe |
| rxData | input | 8 | Received byte |
| txTake | input | 1 | Engine consumed txData, advance to the next byte |
| txData | output | 8 | Byte to transmit |
| wpIn | input | 1 | Write protect |
| portIn | input | 5 | Input port to snapshot |
| codeIn | input | 64 | Code word from the external generator |
| regA | output | 8 | Output register A (shared select in 7:6) |
| regB | output | 8 | Output register B (shared select in 7:6) |
| muxUpdate | output | 1 | One-cycle pulse after a committed register write |
| stretchReq | output | 1 | Clock-stretch request while the write is busy |

## Verification
Two functions can fall in the same cycle: a STOP that commits a staged register write, and a START that opens the next transaction and takes the input snapshot. The bench drives stopSeen and startSeen in the same cycle after a staged write to register A, with portIn set to a new value. It then checks that regA took the new data and that muxUpdate pulsed. A plain read in the new transaction must return the snapshot taken in that shared cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int BYTE_W     = 8;
  localparam int SEED_BYTES = 8;
  localparam int CODE_W     = BYTE_W * SEED_BYTES;
  localparam int PORT_W     = 5;
  localparam int LOW_W      = 6;
  localparam int SEED_IDX_W = $clog2(SEED_BYTES);
  localparam int VID_COUNT  = 3;

  localparam logic [BYTE_W-1:0] CMD_REG_A   = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_REG_B   = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_SEED_WR = 8'hC0;
  localparam logic [BYTE_W-1:0] CMD_SEED_RD = 8'hC1;
  localparam logic [BYTE_W-1:0] CMD_CODE_RD = 8'hC3;

  typedef enum logic [1:0] {TX_VID, TX_SEED, TX_CODE} txMode_t;

  typedef struct packed {
    logic                  snapLoad;
    logic                  stageLoad;
    logic                  seedLoad;
    logic [SEED_IDX_W-1:0] seedIdx;
    logic                  commitReg;
    logic                  regSelB;
    logic                  commitSeed;
    logic                  txClear;
    logic                  txAdvance;
    txMode_t               txMode;
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              timeoutSeen,
  input  logic              addrHit,
  input  logic              addrRead,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              txTake,
  input  logic              wpIn,
  output seqStrobe_t        ctl
);
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_REGDATA, S_SCNT, S_SEED, S_READ, S_SKIP} state_t;

  state_t                state;
  logic                  pendReg, pendSeed, regIsB;
  logic [SEED_IDX_W-1:0] seedIdx;
  txMode_t               pendCmd, txMode;
  logic                  quiet;

  assign quiet = !startSeen && !stopSeen && !timeoutSeen;

  always_comb begin
    ctl            = '0;
    ctl.snapLoad   = startSeen;
    ctl.stageLoad  = quiet && rxValid && state == S_REGDATA;
    ctl.seedLoad   = quiet && rxValid && state == S_SEED;
    ctl.seedIdx    = seedIdx;
    ctl.commitReg  = stopSeen && !timeoutSeen && pendReg && !wpIn;
    ctl.commitSeed = stopSeen && !timeoutSeen && pendSeed && !wpIn;
    ctl.regSelB    = regIsB;
    ctl.txClear    = quiet && addrHit && addrRead;
    ctl.txAdvance  = txTake && state == S_READ;
    ctl.txMode     = txMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pendReg  <= 1'b0;
      pendSeed <= 1'b0;
      regIsB   <= 1'b0;
      seedIdx  <= '0;
      pendCmd  <= TX_VID;
      txMode   <= TX_VID;
    end else if (timeoutSeen || stopSeen) begin
      state    <= S_IDLE;
      pendReg  <= 1'b0;
      pendSeed <= 1'b0;
      pendCmd  <= TX_VID;
    end else if (startSeen) begin
      state    <= S_IDLE;
      pendReg  <= 1'b0;
      pendSeed <= 1'b0;
    end else if (addrHit) begin
      if (addrRead) begin
        state  <= S_READ;
        txMode <= pendCmd;
      end else begin
        state   <= S_CMD;
        pendCmd <= TX_VID;
      end
    end else if (rxValid) begin
      case (state)
        S_CMD: begin
          state <= S_SKIP;
          if (rxData == CMD_REG_A || rxData == CMD_REG_B) begin
            regIsB <= (rxData == CMD_REG_B);
            state  <= S_REGDATA;
          end else if (rxData == CMD_SEED_WR) begin
            state <= S_SCNT;
          end else if (rxData == CMD_SEED_RD) begin
            pendCmd <= TX_SEED;
          end else if (rxData == CMD_CODE_RD) begin
            pendCmd <= TX_CODE;
          end
        end
        S_REGDATA: begin
          pendReg <= 1'b1;
          state   <= S_SKIP;
        end
        S_SCNT: begin
          seedIdx <= '0;
          state   <= (rxData == BYTE_W'(SEED_BYTES)) ? S_SEED : S_SKIP;
        end
        S_SEED: begin
          if (seedIdx == SEED_IDX_W'(SEED_BYTES - 1)) begin
            pendSeed <= 1'b1;
            state    <= S_SKIP;
          end else begin
            seedIdx <= seedIdx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R9: a register write may only be committed by a STOP that follows a data byte
  a_r9_commit_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitReg |-> !$past(timeoutSeen) && ($past(state) == S_SKIP || $past(state) == S_IDLE));
endmodule

// File: rtl/seq_data.sv
module seq_data
  import seq_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        ctl,
  input  logic [BYTE_W-1:0] rxData,
  input  logic [PORT_W-1:0] portIn,
  input  logic [CODE_W-1:0] codeIn,
  output logic [BYTE_W-1:0] txData,
  output logic [BYTE_W-1:0] regA,
  output logic [BYTE_W-1:0] regB,
  output logic              muxUpdate,
  output logic              stretchReq
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int TX_W   = $clog2(SEED_BYTES + 2);
  localparam int SEL_W  = BYTE_W - LOW_W;

  logic [SEL_W-1:0]  selBits;
  logic [LOW_W-1:0]  lowA, lowB;
  logic [BYTE_W-1:0] stage;
  logic [BYTE_W-1:0] seedStage [SEED_BYTES];
  logic [CODE_W-1:0] seed, stagedSeed, blockSrc;
  logic [PORT_W-1:0] snap;
  logic [BUSY_W-1:0] busy;
  logic [TX_W-1:0]   txIdx;

  assign regA       = {selBits, lowA};
  assign regB       = {selBits, lowB};
  assign stretchReq = (busy != '0);

  for (genvar g = 0; g < SEED_BYTES; g++) begin : g_stage
    assign stagedSeed[CODE_W-1-g*BYTE_W -: BYTE_W] = seedStage[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selBits   <= 2'b10;
      lowA      <= '0;
      lowB      <= '0;
      stage     <= '0;
      seed      <= '0;
      snap      <= '0;
      busy      <= '0;
      txIdx     <= '0;
      muxUpdate <= 1'b0;
      for (int i = 0; i < SEED_BYTES; i++) seedStage[i] <= '0;
    end else begin
      muxUpdate <= ctl.commitReg;
      if (ctl.snapLoad)  snap  <= portIn;
      if (ctl.stageLoad) stage <= rxData;
      if (ctl.seedLoad)  seedStage[ctl.seedIdx] <= rxData;
      if (ctl.commitReg) begin
        selBits <= stage[BYTE_W-1:LOW_W];
        if (ctl.regSelB) lowB <= stage[LOW_W-1:0];
        else             lowA <= stage[LOW_W-1:0];
      end
      if (ctl.commitSeed) seed <= stagedSeed;
      if (ctl.commitReg || ctl.commitSeed) busy <= BUSY_W'(BUSY_CYCLES);
      else if (busy != '0)                 busy <= busy - 1'b1;
      if (ctl.txClear) txIdx <= '0;
      else if (ctl.txAdvance && txIdx != TX_W'(SEED_BYTES + 1)) txIdx <= txIdx + 1'b1;
    end
  end

  assign blockSrc = (ctl.txMode == TX_CODE) ? (codeIn | {1'b1, {(CODE_W-1){1'b0}}}) : seed;

  always_comb begin
    txData = 8'hFF;
    if (ctl.txMode == TX_VID) begin
      if      (txIdx == TX_W'(0)) txData = BYTE_W'(VID_COUNT);
      else if (txIdx == TX_W'(1)) txData = regA;
      else if (txIdx == TX_W'(2)) txData = regB;
      else if (txIdx == TX_W'(3)) txData = BYTE_W'(snap);
    end else begin
      if (txIdx == TX_W'(0))
        txData = BYTE_W'(SEED_BYTES);
      else if (int'(txIdx) <= SEED_BYTES)
        txData = BYTE_W'(blockSrc >> ((SEED_BYTES - int'(txIdx)) * BYTE_W));
    end
  end

  // R7: first code byte always has its top bit set
  a_r7_code_msb: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.txMode == TX_CODE && txIdx == TX_W'(1)) |-> txData[BYTE_W-1]);
  // R10: the busy window only opens after a commit
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stretchReq) |-> $past(ctl.commitReg || ctl.commitSeed));
endmodule

// File: rtl/smbus_seq_top.sv
module smbus_seq_top
  import seq_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              timeoutSeen,
  input  logic              addrHit,
  input  logic              addrRead,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              txTake,
  output logic [7:0]        txData,
  input  logic              wpIn,
  input  logic [4:0]        portIn,
  input  logic [63:0]       codeIn,
  output logic [7:0]        regA,
  output logic [7:0]        regB,
  output logic              muxUpdate,
  output logic              stretchReq
);
  seqStrobe_t ctl;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .timeoutSeen(timeoutSeen), .addrHit(addrHit), .addrRead(addrRead),
    .rxValid(rxValid), .rxData(rxData), .txTake(txTake), .wpIn(wpIn), .ctl(ctl)
  );

  seq_data #(.BUSY_CYCLES(BUSY_CYCLES)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData), .portIn(portIn),
    .codeIn(codeIn), .txData(txData), .regA(regA), .regB(regB),
    .muxUpdate(muxUpdate), .stretchReq(stretchReq)
  );

  // R8: a protected STOP leaves the registers alone and starts no busy window
  a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && wpIn) |=> $stable(regA) && $stable(regB) && !muxUpdate);
  // R9: the update pulse follows a STOP
  a_r9_update_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    muxUpdate |-> $past(stopSeen));
  // R10: the stretch request rises only right after a STOP
  a_r10_stretch_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stretchReq) |-> $past(stopSeen));
  // R2: registers change only right after a STOP
  a_r2_regs_at_stop: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stopSeen) |-> $stable(regA) && $stable(regB));
endmodule

// File: tb/tb_smbus_seq_top.sv
module tb_smbus_seq_top;
  logic clk = 0, rstN = 0;
  logic startSeen = 0, stopSeen = 0, timeoutSeen = 0, addrHit = 0, addrRead = 0;
  logic rxValid = 0, txTake = 0, wpIn = 0;
  logic [7:0] rxData = 0;
  logic [4:0] portIn = 0;
  logic [63:0] codeIn = 0;
  logic [7:0] txData, regA, regB;
  logic muxUpdate, stretchReq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smbus_seq_top #(.BUSY_CYCLES(16)) dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pStart(); @(negedge clk) startSeen = 1; @(negedge clk) startSeen = 0; endtask
  task automatic pStop();  @(negedge clk) stopSeen = 1;  @(negedge clk) stopSeen = 0;  endtask
  task automatic pTimeout(); @(negedge clk) timeoutSeen = 1; @(negedge clk) timeoutSeen = 0; endtask
  task automatic pAddr(logic rd);
    @(negedge clk) begin addrHit = 1; addrRead = rd; end
    @(negedge clk) addrHit = 0;
  endtask
  task automatic pByte(logic [7:0] b);
    @(negedge clk) begin rxValid = 1; rxData = b; end
    @(negedge clk) rxValid = 0;
  endtask
  task automatic expectTx(string tag, logic [7:0] exp);
    chk(tag, txData, exp);
    @(negedge clk) txTake = 1;
    @(negedge clk) txTake = 0;
  endtask
  task automatic stageWrite(logic [7:0] r, logic [7:0] d);
    pStart(); pAddr(0); pByte(r); pByte(d);
  endtask
  task automatic waitIdle();
    while (stretchReq) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R2 reset regA", regA, 8'h80);
    chk("R2 reset regB", regB, 8'h80);
    chk("R10 reset stretch", stretchReq, 0);
    chk("R9 reset update", muxUpdate, 0);
  endtask

  task automatic tWriteA();
    int hi = 0;
    stageWrite(8'h00, 8'h15);
    chk("R1 regA before STOP", regA, 8'h80);
    pStop();
    chk("R1 regA after STOP", regA, 8'h15);
    chk("R2 regB shares select", regB, 8'h00);
    chk("R9 update pulse", muxUpdate, 1);
    while (stretchReq) begin hi++; @(negedge clk); end
    chk("R10 stretch length", hi, 16);
    chk("R9 update one cycle", muxUpdate, 0);
  endtask

  task automatic tWriteB();
    stageWrite(8'h01, 8'h6A); pStop();
    chk("R1 regB written", regB, 8'h6A);
    chk("R2 regA select follows", regA, 8'h55);
    waitIdle();
  endtask

  task automatic tPlainRead();
    portIn = 5'h13;
    pStart();
    portIn = 5'h0C;
    pAddr(1);
    expectTx("R3 count", 8'h03);
    expectTx("R3 regA", 8'h55);
    expectTx("R3 regB", 8'h6A);
    expectTx("R4 snapshot", 8'h13);
    expectTx("R3 beyond", 8'hFF);
    pStop();
  endtask

  task automatic tProtect();
    wpIn = 1;
    stageWrite(8'h00, 8'h3F); pStop();
    chk("R8 regA kept", regA, 8'h55);
    chk("R8 no update", muxUpdate, 0);
    chk("R8 no stretch", stretchReq, 0);
    wpIn = 0;
  endtask

  task automatic tAbort();
    stageWrite(8'h00, 8'h22); pStart(); pStop();
    chk("R9 restart discards", regA, 8'h55);
    chk("R9 restart no pulse", muxUpdate, 0);
    stageWrite(8'h01, 8'h33); pTimeout(); pStop();
    chk("R9 timeout discards", regB, 8'h6A);
    chk("R9 timeout no stretch", stretchReq, 0);
  endtask

  task automatic tSeed();
    pStart(); pAddr(0); pByte(8'hC0); pByte(8'h08);
    for (int i = 1; i <= 8; i++) pByte(8'(i * 8'h11));
    pStop(); waitIdle();
    pStart(); pAddr(0); pByte(8'hC0); pByte(8'h07);
    for (int i = 0; i < 8; i++) pByte(8'hEE);
    pStop(); waitIdle();
    pStart(); pAddr(0); pByte(8'hC1); pStart(); pAddr(1);
    expectTx("R6 seed count", 8'h08);
    for (int i = 1; i <= 8; i++) expectTx("R5 R6 seed byte", 8'(i * 8'h11));
    pStop();
  endtask

  task automatic tCode();
    codeIn = 64'h0123456789ABCDEF;
    pStart(); pAddr(0); pByte(8'hC3); pStart(); pAddr(1);
    expectTx("R7 code count", 8'h08);
    expectTx("R7 code msb forced", 8'h81);
    for (int i = 1; i < 8; i++) expectTx("R7 code byte", codeIn[63-8*i -: 8]);
    pStop();
  endtask

  task automatic tStopStart();
    stageWrite(8'h00, 8'h8C);
    portIn = 5'h1E;
    @(negedge clk) begin stopSeen = 1; startSeen = 1; end
    @(negedge clk) begin stopSeen = 0; startSeen = 0; end
    portIn = 5'h01;
    chk("R11 commit with start", regA, 8'h8C);
    chk("R11 update pulse", muxUpdate, 1);
    pAddr(1);
    expectTx("R11 count", 8'h03);
    expectTx("R11 regA", 8'h8C);
    expectTx("R11 regB", 8'hAA);
    expectTx("R11 snapshot", 8'h1E);
    pStop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset(); tWriteA(); tWriteB(); tPlainRead(); tProtect();
    tAbort(); tSeed(); tCode(); tStopStart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule